// File: doc/BRIEF.md
# Row-Hit-First DRAM Request Scheduler

This block holds the pending read and write requests of a single-rank, single-channel DRAM controller that keeps rows open, and picks the next one to serve. Each request carries a bank, a row, a column and a direction bit. On entry the block stamps it with an arrival count, so that requests can be ranked by age. A table of the row open in each bank decides whether a pending request is a row-hit or a row-conflict.

On every cycle the selected request is offered at the grant port, together with a flag that says whether it hits the open row. Requests that hit go before requests that miss, and the oldest goes first within each group. A bounded counter stops a stream of hits from starving an older conflicting request: once the limit is reached, the oldest conflict is served next. Command timing, refresh and the data path belong to the command engine that consumes the grants.

Top module: `dram_frfcfs_sched`

## Requirements
- R1: A pending request is a row-hit when its bank has an open row and that row equals the request row. Otherwise it is a row-conflict. `grant_hit_o` is 1 for a row-hit and 0 for a row-conflict.
- R2: While at least one row-hit is pending and the bypass limit has not been reached, the granted request is a row-hit.
- R3: Among pending row-hits, the one accepted earliest is granted first.
- R4: When no row-hit is pending, the oldest pending row-conflict is granted.
- R5: After reset every bank is closed, so the first request granted to any bank is a row-conflict.
- R6: A granted request leaves its row open in its bank. The open row of a bank changes only when a conflicting request to that bank is granted.
- R7: Suppose a row-conflict is pending and row-hits younger than it have been granted while it waited. After ROWHIT_MAX such hits, where ROWHIT_MAX = min(2**COL_W / BURST_LEN, HIT_CAP) (4 with the defaults), the oldest pending row-conflict is granted next, even if row-hits are pending.
- R8: The bypass count restarts from zero each time a row-conflict is granted. A later conflict may therefore again be passed by up to ROWHIT_MAX hits.
- R9: The queue holds DEPTH requests (8 by default). `req_ready_o` is 1 exactly when fewer than DEPTH requests are held. A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both 1.
- R10: `grant_valid_o` is 1 exactly when the queue holds a request. The granted request leaves the queue on a clock edge where `grant_valid_o` and `grant_ready_i` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | A new request is offered |
| req_ready_o | output | 1 | Queue has a free slot |
| req_bank_i | input | BANK_W | Bank of the new request |
| req_row_i | input | ROW_W | Row of the new request |
| req_col_i | input | COL_W | Column of the new request |
| req_wr_i | input | 1 | 1 for write, 0 for read |
| grant_valid_o | output | 1 | A selected request is offered |
| grant_ready_i | input | 1 | Consumer takes the selected request |
| grant_bank_o | output | BANK_W | Bank of the selected request |
| grant_row_o | output | ROW_W | Row of the selected request |
| grant_col_o | output | COL_W | Column of the selected request |
| grant_wr_o | output | 1 | Direction of the selected request |
| grant_hit_o | output | 1 | 1 if the selected request is a row-hit |

## Verification
The bench first loads a batch of requests with the grant side held off, then drains the batch and compares the grant order with a hand-derived sequence. One batch to closed banks shows whether the age order and the first-access conflict hold. A mix of stale-row and open-row requests separates hit priority from plain age order. A follow-up request to a row kept open tells whether a served row stays open. Long runs of hits behind one older conflict expose an off-by-one in the bypass limit. A second run of the same shape shows whether the counter restarts after a conflict is granted. A batch that fills the queue checks back-pressure.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

    // Which rule produced the current selection.
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_HIT    = 2'd1,
        SRC_AGE    = 2'd2,
        SRC_FORCED = 2'd3
    } pick_src_e;

    function automatic int unsigned umin(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/dfs_queue.sv
// Request storage: unordered slots, each stamped with an arrival count.
module dfs_queue #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned BANK_W = 3,
    parameter int unsigned ROW_W  = 14,
    parameter int unsigned COL_W  = 10,
    parameter int unsigned TS_W   = 16,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              enq_i,
    input  logic [BANK_W-1:0] enq_bank_i,
    input  logic [ROW_W-1:0]  enq_row_i,
    input  logic [COL_W-1:0]  enq_col_i,
    input  logic              enq_wr_i,
    input  logic              deq_i,
    input  logic [IDX_W-1:0]  deq_idx_i,
    output logic [DEPTH-1:0]  vld_o,
    output logic [BANK_W-1:0] bank_o [DEPTH],
    output logic [ROW_W-1:0]  row_o  [DEPTH],
    output logic [COL_W-1:0]  col_o  [DEPTH],
    output logic [DEPTH-1:0]  wr_o,
    output logic [TS_W-1:0]   ts_o   [DEPTH],
    output logic              full_o
);

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][BANK_W-1:0] bank;
        logic [DEPTH-1:0][ROW_W-1:0]  row;
        logic [DEPTH-1:0][COL_W-1:0]  col;
        logic [DEPTH-1:0]             wr;
        logic [DEPTH-1:0][TS_W-1:0]   ts;
        logic [TS_W-1:0]              stamp;
    } q_t;

    q_t q_d, q_q;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        q_d      = q_q;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!q_q.vld[i]) free_idx = IDX_W'(i);
        end
        if (deq_i) q_d.vld[deq_idx_i] = 1'b0;
        if (enq_i && !(&q_q.vld)) begin
            q_d.vld[free_idx]  = 1'b1;
            q_d.bank[free_idx] = enq_bank_i;
            q_d.row[free_idx]  = enq_row_i;
            q_d.col[free_idx]  = enq_col_i;
            q_d.wr[free_idx]   = enq_wr_i;
            q_d.ts[free_idx]   = q_q.stamp;
            q_d.stamp          = q_q.stamp + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q_q <= '0;
        else         q_q <= q_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_out
        assign bank_o[g] = q_q.bank[g];
        assign row_o[g]  = q_q.row[g];
        assign col_o[g]  = q_q.col[g];
        assign ts_o[g]   = q_q.ts[g];
    end

    assign vld_o  = q_q.vld;
    assign wr_o   = q_q.wr;
    assign full_o = &q_q.vld;

endmodule

// File: rtl/dfs_openrow.sv
// Per-bank open-row table and per-slot hit detection.
module dfs_openrow #(
    parameter int unsigned NBANK  = 8,
    parameter int unsigned BANK_W = 3,
    parameter int unsigned ROW_W  = 14,
    parameter int unsigned DEPTH  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              upd_i,
    input  logic [BANK_W-1:0] upd_bank_i,
    input  logic [ROW_W-1:0]  upd_row_i,
    input  logic [BANK_W-1:0] bank_i [DEPTH],
    input  logic [ROW_W-1:0]  row_i  [DEPTH],
    output logic [DEPTH-1:0]  hit_o
);

    typedef struct packed {
        logic [NBANK-1:0]            open;
        logic [NBANK-1:0][ROW_W-1:0] orow;
    } tbl_t;

    tbl_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (upd_i) begin
            t_d.open[upd_bank_i] = 1'b1;
            t_d.orow[upd_bank_i] = upd_row_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) t_q <= '0;
        else         t_q <= t_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_hit
        assign hit_o[g] = t_q.open[bank_i[g]] && (t_q.orow[bank_i[g]] == row_i[g]);
    end

endmodule

// File: rtl/dfs_pick.sv
// Selection: oldest hit first, oldest conflict when no hit or when forced.
module dfs_pick #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned TS_W   = 16,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] vld_i,
    input  logic [DEPTH-1:0] hit_i,
    input  logic [TS_W-1:0]  ts_i [DEPTH],
    input  logic             force_conf_i,
    output logic             sel_valid_o,
    output logic [IDX_W-1:0] sel_idx_o,
    output logic             sel_hit_o,
    output logic             older_conf_o
);
    import dfs_pkg::*;

    // Modular age compare: a arrived before b.
    function automatic logic ts_older(input logic [TS_W-1:0] a, input logic [TS_W-1:0] b);
        logic [TS_W-1:0] diff;
        diff = a - b;
        return diff[TS_W-1];
    endfunction

    logic             hit_f, conf_f;
    logic [IDX_W-1:0] hit_ix, conf_ix;
    pick_src_e        src;

    always_comb begin
        hit_f   = 1'b0;
        conf_f  = 1'b0;
        hit_ix  = '0;
        conf_ix = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld_i[i] && hit_i[i]) begin
                if (!hit_f || ts_older(ts_i[i], ts_i[hit_ix])) begin
                    hit_f  = 1'b1;
                    hit_ix = IDX_W'(i);
                end
            end
            if (vld_i[i] && !hit_i[i]) begin
                if (!conf_f || ts_older(ts_i[i], ts_i[conf_ix])) begin
                    conf_f  = 1'b1;
                    conf_ix = IDX_W'(i);
                end
            end
        end

        if (force_conf_i && conf_f) src = SRC_FORCED;
        else if (hit_f)             src = SRC_HIT;
        else if (conf_f)            src = SRC_AGE;
        else                        src = SRC_NONE;

        case (src)
            SRC_HIT:             sel_idx_o = hit_ix;
            SRC_AGE, SRC_FORCED: sel_idx_o = conf_ix;
            default:             sel_idx_o = '0;
        endcase

        sel_valid_o  = (src != SRC_NONE);
        sel_hit_o    = (src == SRC_HIT);
        older_conf_o = conf_f && ts_older(ts_i[conf_ix], ts_i[sel_idx_o]);
    end

endmodule

// File: rtl/dram_frfcfs_sched.sv
module dram_frfcfs_sched #(
    parameter int unsigned DEPTH     = 8,
    parameter int unsigned NBANK     = 8,
    parameter int unsigned ROW_W     = 14,
    parameter int unsigned COL_W     = 10,
    parameter int unsigned BURST_LEN = 8,
    parameter int unsigned HIT_CAP   = 4,
    parameter int unsigned TS_W      = 16,
    localparam int unsigned BANK_W   = $clog2(NBANK)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [BANK_W-1:0] req_bank_i,
    input  logic [ROW_W-1:0]  req_row_i,
    input  logic [COL_W-1:0]  req_col_i,
    input  logic              req_wr_i,
    output logic              grant_valid_o,
    input  logic              grant_ready_i,
    output logic [BANK_W-1:0] grant_bank_o,
    output logic [ROW_W-1:0]  grant_row_o,
    output logic [COL_W-1:0]  grant_col_o,
    output logic              grant_wr_o,
    output logic              grant_hit_o
);

    localparam int unsigned IDX_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned ROWHIT_MAX = dfs_pkg::umin((2 ** COL_W) / BURST_LEN, HIT_CAP);
    localparam int unsigned CNT_W      = $clog2(ROWHIT_MAX + 1);

    typedef struct packed {
        logic [CNT_W-1:0] byp;
    } st_t;

    st_t st_d, st_q;

    logic [DEPTH-1:0]  vld, hit, wr;
    logic [BANK_W-1:0] bank [DEPTH];
    logic [ROW_W-1:0]  row  [DEPTH];
    logic [COL_W-1:0]  col  [DEPTH];
    logic [TS_W-1:0]   ts   [DEPTH];
    logic              full, sel_valid, sel_hit, older_conf, force_conf, fire;
    logic [IDX_W-1:0]  sel_idx;

    assign req_ready_o = !full;
    assign force_conf  = (st_q.byp == CNT_W'(ROWHIT_MAX));
    assign fire        = sel_valid && grant_ready_i;

    dfs_queue #(
        .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .TS_W(TS_W)
    ) queue_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .enq_i      (req_valid_i && req_ready_o),
        .enq_bank_i (req_bank_i),
        .enq_row_i  (req_row_i),
        .enq_col_i  (req_col_i),
        .enq_wr_i   (req_wr_i),
        .deq_i      (fire),
        .deq_idx_i  (sel_idx),
        .vld_o      (vld),
        .bank_o     (bank),
        .row_o      (row),
        .col_o      (col),
        .wr_o       (wr),
        .ts_o       (ts),
        .full_o     (full)
    );

    dfs_openrow #(
        .NBANK(NBANK), .BANK_W(BANK_W), .ROW_W(ROW_W), .DEPTH(DEPTH)
    ) openrow_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .upd_i      (fire && !sel_hit),
        .upd_bank_i (bank[sel_idx]),
        .upd_row_i  (row[sel_idx]),
        .bank_i     (bank),
        .row_i      (row),
        .hit_o      (hit)
    );

    dfs_pick #(
        .DEPTH(DEPTH), .TS_W(TS_W)
    ) pick_i (
        .vld_i        (vld),
        .hit_i        (hit),
        .ts_i         (ts),
        .force_conf_i (force_conf),
        .sel_valid_o  (sel_valid),
        .sel_idx_o    (sel_idx),
        .sel_hit_o    (sel_hit),
        .older_conf_o (older_conf)
    );

    always_comb begin
        st_d = st_q;
        if (fire) begin
            if (!sel_hit)        st_d.byp = '0;
            else if (older_conf) st_d.byp = st_q.byp + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign grant_valid_o = sel_valid;
    assign grant_bank_o  = bank[sel_idx];
    assign grant_row_o   = row[sel_idx];
    assign grant_col_o   = col[sel_idx];
    assign grant_wr_o    = wr[sel_idx];
    assign grant_hit_o   = sel_hit;

endmodule

// File: rtl/dfs_sched_chk.sv
module dfs_sched_chk #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned NBANK  = 8,
    parameter int unsigned ROW_W  = 14,
    parameter int unsigned BANK_W = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic              grant_valid_o,
    input logic              grant_ready_i,
    input logic [BANK_W-1:0] grant_bank_o,
    input logic [ROW_W-1:0]  grant_row_o,
    input logic              grant_hit_o
);

    localparam int unsigned OCC_W = $clog2(DEPTH + 1);

    logic [OCC_W-1:0] occ_q;
    logic [NBANK-1:0] mopen_q;
    logic [ROW_W-1:0] mrow_q [NBANK];
    logic             take, put;

    assign put  = req_valid_i && req_ready_o;
    assign take = grant_valid_o && grant_ready_i;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            occ_q   <= '0;
            mopen_q <= '0;
            for (int b = 0; b < NBANK; b++) mrow_q[b] <= '0;
        end else begin
            occ_q <= occ_q + OCC_W'(put) - OCC_W'(take);
            if (take) begin
                mopen_q[grant_bank_o] <= 1'b1;
                mrow_q[grant_bank_o]  <= grant_row_o;
            end
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        occ_q <= OCC_W'(DEPTH));

    // R9
    ready_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_ready_o == (occ_q < OCC_W'(DEPTH)));

    // R10
    grant_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_valid_o == (occ_q != '0));

    // R1
    hit_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_valid_o |-> (grant_hit_o == (mopen_q[grant_bank_o] && (mrow_q[grant_bank_o] == grant_row_o))));

endmodule

bind dram_frfcfs_sched dfs_sched_chk #(
    .DEPTH(DEPTH), .NBANK(NBANK), .ROW_W(ROW_W), .BANK_W(BANK_W)
) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_ready_o   (req_ready_o),
    .grant_valid_o (grant_valid_o),
    .grant_ready_i (grant_ready_i),
    .grant_bank_o  (grant_bank_o),
    .grant_row_o   (grant_row_o),
    .grant_hit_o   (grant_hit_o)
);

// File: tb/dram_frfcfs_sched_tb_top.sv
module dram_frfcfs_sched_tb_top;

    localparam int BANK_W = 3;
    localparam int ROW_W  = 14;
    localparam int COL_W  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_wr = 1'b0, grant_ready = 1'b0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic req_ready, grant_valid, grant_wr, grant_hit;
    logic [BANK_W-1:0] grant_bank;
    logic [ROW_W-1:0]  grant_row;
    logic [COL_W-1:0]  grant_col;

    int checks = 0;
    int errors = 0;

    typedef struct {
        int    bank;
        int    row;
        int    col;
        bit    wr;
        bit    hit;
        string rq;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    dram_frfcfs_sched dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col), .req_wr_i(req_wr),
        .grant_valid_o(grant_valid), .grant_ready_i(grant_ready),
        .grant_bank_o(grant_bank), .grant_row_o(grant_row), .grant_col_o(grant_col),
        .grant_wr_o(grant_wr), .grant_hit_o(grant_hit)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic enq(input int b, input int r, input int c, input bit w);
        @(posedge clk); #1;
        req_valid = 1'b1;
        req_bank  = BANK_W'(b);
        req_row   = ROW_W'(r);
        req_col   = COL_W'(c);
        req_wr    = w;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic expect_grant(input int b, input int r, input int c, input bit w,
                                input bit h, input string rq);
        exp_t e;
        e.bank = b; e.row = r; e.col = c; e.wr = w; e.hit = h; e.rq = rq;
        exp_q.push_back(e);
    endtask

    task automatic drain();
        @(posedge clk); #1;
        grant_ready = 1'b1;
        while (exp_q.size() != 0) @(posedge clk);
        #1 grant_ready = 1'b0;
        @(negedge clk);
        // R10: empty queue offers nothing
        check(grant_valid == 1'b0, "R10 empty after drain", int'(grant_valid), 0);
    endtask

    // Monitor: compare every taken grant with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && grant_valid && grant_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected grant", int'(grant_col), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(int'(grant_col) == e.col, {e.rq, " col"}, int'(grant_col), e.col);
                check(int'(grant_bank) == e.bank && int'(grant_row) == e.row && grant_wr == e.wr,
                      {e.rq, " bank/row/wr"}, int'({grant_bank, grant_row, grant_wr}),
                      int'({BANK_W'(e.bank), ROW_W'(e.row), e.wr}));
                check(grant_hit == e.hit, {e.rq, " hit flag"}, int'(grant_hit), int'(e.hit));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9 / R10: reset state
        check(req_ready == 1'b1, "R9 ready after reset", int'(req_ready), 1);
        check(grant_valid == 1'b0, "R10 no grant after reset", int'(grant_valid), 0);

        // Closed banks: oldest conflict first, then the hit it opens
        enq(0, 5, 1, 0); enq(0, 5, 2, 1); enq(1, 3, 3, 0);
        expect_grant(0, 5, 1, 0, 0, "R5 first access conflict");
        expect_grant(0, 5, 2, 1, 1, "R1 hit on opened row");
        expect_grant(1, 3, 3, 0, 0, "R4 oldest conflict");
        drain();

        // Hits pass an older conflict, hits in age order
        enq(0, 7, 4, 0); enq(1, 3, 5, 1); enq(0, 5, 6, 0);
        expect_grant(1, 3, 5, 1, 1, "R3 oldest hit");
        expect_grant(0, 5, 6, 0, 1, "R2 hit before conflict");
        expect_grant(0, 7, 4, 0, 0, "R4 conflict after hits");
        drain();

        // Row stays open after being served
        enq(0, 7, 7, 1);
        expect_grant(0, 7, 7, 1, 1, "R6 row kept open");
        drain();

        // Bypass limit: four hits, then the older conflict
        enq(0, 9, 8, 0);
        for (int i = 0; i < 6; i++) enq(1, 3, 9 + i, i[0]);
        for (int i = 0; i < 4; i++) expect_grant(1, 3, 9 + i, i[0], 1, "R7 hit within limit");
        expect_grant(0, 9, 8, 0, 0, "R7 forced conflict");
        expect_grant(1, 3, 13, 0, 1, "R7 hit after conflict");
        expect_grant(1, 3, 14, 1, 1, "R7 hit after conflict");
        drain();

        // Counter restarted: a new conflict again waits four hits
        enq(0, 1, 20, 1);
        for (int i = 0; i < 5; i++) enq(1, 3, 21 + i, 0);
        for (int i = 0; i < 4; i++) expect_grant(1, 3, 21 + i, 0, 1, "R8 restart allows hits");
        expect_grant(0, 1, 20, 1, 0, "R8 conflict after four");
        expect_grant(1, 3, 25, 0, 1, "R8 trailing hit");
        drain();

        // Fill the queue
        for (int i = 0; i < 8; i++) enq(3, 2, 30 + i, i[0]);
        @(negedge clk);
        check(req_ready == 1'b0, "R9 ready low when full", int'(req_ready), 0);
        check(grant_valid == 1'b1, "R10 grant offered", int'(grant_valid), 1);
        expect_grant(3, 2, 30, 0, 0, "R5 closed bank conflict");
        for (int i = 1; i < 8; i++) expect_grant(3, 2, 30 + i, i[0], 1, "R3 hits in order");
        drain();
        @(negedge clk);
        check(req_ready == 1'b1, "R9 ready after drain", int'(req_ready), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule